// File: doc/BRIEF.md
# Tiled/Linear Pixel Transfer Engine with Box Downscale

This engine copies a frame of 32-bit RGBA pixels (four 8-bit channels, 4 bytes per pixel) from a source buffer to a destination buffer. Each side may be stored either linearly or in 8x8 interleaved tiles that are grouped into tile rows. On the way it can optionally halve the image horizontally, or halve it on both axes, by averaging neighbouring source pixels channel by channel.

Software loads the configuration inputs (base addresses, source width and height, scale mode and the layout of each side) and pulses `start`. The engine walks the output image in raster order and issues one read and one write per output pixel. It can sustain one pixel per cycle when both memory ports are ready. A read returns four consecutive source pixels in one beat, so a whole averaging group arrives at once. Completion is shown by `busy` falling together with a one-cycle `done` pulse. A configuration that cannot be served is refused at start: `errFlag` is raised and no memory access takes place.

Top module: `dtx_engine`

## Requirements
- R1: `cfgScale` encodes 0 = copy, 1 = halve horizontally, 2 = halve both axes. Value 3 is refused at start: `errFlag` becomes 1, `busy` stays 0, and no read or write handshake occurs.
- R2: A start with linear source layout (`cfgInTiled`=0) and a non-zero scale mode is refused in the same way as R1.
- R3: The output width is `cfgWidth>>1` in modes 1 and 2, and `cfgWidth` otherwise. The output height is `cfgHeight>>1` only in mode 2. Exactly width×height reads and writes occur, and the writes are in raster order (x fastest). A zero-area output completes with no memory traffic.
- R4: The tiled byte offset of (x,y) in an image of width w is 4×(m + (x>>3)×64 + (y>>3)×8×w). Here m is the 6-bit index {y2,x2,y1,x1,y0,x0}, with x0 as its least significant bit.
- R5: The linear byte offset of (x,y) in an image of width w is 4×(x + y×w).
- R6: The source pixel for output (x,y) has x doubled in modes 1 and 2 and y doubled in mode 2. The source offset uses `cfgWidth` and the destination offset uses the output width. Read lane k (`rdData` bits 32k+31:32k) holds the word at `rdAddr`+4k, and channel c is bits 8c+7:8c of a pixel. Mode 0 writes lane 0 unchanged. Mode 1 writes floor((lane0+lane1)/2) per channel. Mode 2 writes floor((lane0+lane1+lane2+lane3)/4) per channel.
- R7: `busy` is 1 from the cycle after an accepted start until completion. `done` is a one-cycle pulse, raised after the last write has been accepted, and `busy` is 0 while it is high.
- R8: While `wrValid` is 1 and `wrReady` is 0, `wrValid`, `wrAddr` and `wrData` hold their values.
- R9: After reset, `busy`, `done`, `errFlag`, `rdValid` and `wrValid` are 0. An accepted start with a supported mode clears `errFlag`.
- R10: A `start` pulse while `busy` is 1 is ignored: the transfer in progress and `errFlag` are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| cfgSrcBase | input | ADDR_W | Source buffer byte address |
| cfgDstBase | input | ADDR_W | Destination buffer byte address |
| cfgWidth | input | DIM_W | Source width in pixels |
| cfgHeight | input | DIM_W | Source height in pixels |
| cfgScale | input | 2 | Scale mode (R1) |
| cfgInTiled | input | 1 | Source layout: 1 tiled, 0 linear |
| cfgOutTiled | input | 1 | Destination layout: 1 tiled, 0 linear |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| errFlag | output | 1 | Last start was refused |
| rdValid | output | 1 | Read request valid |
| rdReady | input | 1 | Read request accepted, data present |
| rdAddr | output | ADDR_W | Byte address of read lane 0 |
| rdData | input | 4×32 | Four consecutive source pixels |
| wrValid | output | 1 | Write request valid |
| wrReady | input | 1 | Write accepted |
| wrAddr | output | ADDR_W | Destination byte address |
| wrData | output | 32 | Result pixel |

## Verification
The assertions take for granted that memory presents `rdData` in the same cycle as the read handshake. They also assume that `cfgWidth` and `cfgHeight` fit `DIM_W`, so that doubled source coordinates never wrap. The bench meets both conditions with a memory model that is a pure function of `rdAddr`, evaluated combinationally, and with image sizes of at most 32 pixels. The bench sweeps every layout pair and every scale mode, with the ready inputs held high or stalled in fixed patterns. It predicts each write address and averaged value from the offset formulas. It also drives refused configurations, a zero-area output and a start pulse in the middle of a transfer.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
  localparam int BYTES_PP = 4;
  localparam int CHAN_N   = 4;
  localparam int CHAN_W   = 8;
  localparam int PIX_W    = CHAN_N * CHAN_W;
  localparam int LANES_N  = 4;

  typedef enum logic [1:0] {
    SCL_NONE = 2'd0,
    SCL_X    = 2'd1,
    SCL_XY   = 2'd2,
    SCL_BAD  = 2'd3
  } scale_e;

  typedef struct packed {
    logic loadCfg;
    logic rdFire;
  } ctrl_strobe_t;
endpackage

// File: rtl/dtx_ctrl.sv
module dtx_ctrl
  import dtx_pkg::*;
#(
  parameter int DIM_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIM_W-1:0] cfgWidth,
  input  logic [DIM_W-1:0] cfgHeight,
  input  logic [1:0]       cfgScale,
  input  logic             cfgInTiled,
  input  logic             outFree,
  input  logic             wrIdle,
  input  logic             rdReady,
  output logic             rdValid,
  output logic             busy,
  output logic             done,
  output logic             errFlag,
  output ctrl_strobe_t     strobe,
  output logic [DIM_W-1:0] outW,
  output logic [DIM_W-1:0] outH,
  output logic [DIM_W-1:0] curX,
  output logic [DIM_W-1:0] curY
);
  localparam logic [DIM_W-1:0] ONE = DIM_W'(1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} state_e;
  state_e state;

  logic             badMode, startOk, zeroArea, lastX, lastY;
  logic [DIM_W-1:0] nextW, nextH;

  always_comb begin
    badMode  = (cfgScale == SCL_BAD) || (!cfgInTiled && cfgScale != SCL_NONE);
    startOk  = start && (state == ST_IDLE);
    nextW    = (cfgScale != SCL_NONE) ? (cfgWidth >> 1) : cfgWidth;
    nextH    = (cfgScale == SCL_XY) ? (cfgHeight >> 1) : cfgHeight;
    zeroArea = (nextW == '0) || (nextH == '0);
    lastX    = (curX == outW - ONE);
    lastY    = (curY == outH - ONE);
    rdValid  = (state == ST_RUN) && outFree;
    strobe.rdFire  = rdValid && rdReady;
    strobe.loadCfg = startOk && !badMode;
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      curX    <= '0;
      curY    <= '0;
      outW    <= '0;
      outH    <= '0;
      done    <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (startOk) begin
            errFlag <= badMode;
            if (!badMode) begin
              outW  <= nextW;
              outH  <= nextH;
              curX  <= '0;
              curY  <= '0;
              state <= zeroArea ? ST_DRAIN : ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (strobe.rdFire) begin
            if (lastX) begin
              curX <= '0;
              if (lastY) state <= ST_DRAIN;
              else       curY  <= curY + ONE;
            end else begin
              curX <= curX + ONE;
            end
          end
        end
        ST_DRAIN: begin
          if (wrIdle) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BAD_SCALE_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start && cfgScale == SCL_BAD) |=> (state == ST_IDLE && errFlag)); // R1
  AST_LINEAR_SCALE_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start && !cfgInTiled && cfgScale != SCL_NONE) |=> (state == ST_IDLE && errFlag)); // R2
  AST_COORD_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (curX < outW && curY < outH)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(errFlag) && $stable(outW) && $stable(outH)); // R10
endmodule

// File: rtl/dtx_datapath.sv
module dtx_datapath
  import dtx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrl_strobe_t             strobe,
  input  logic [ADDR_W-1:0]        cfgSrcBase,
  input  logic [ADDR_W-1:0]        cfgDstBase,
  input  logic [DIM_W-1:0]         cfgWidth,
  input  logic [1:0]               cfgScale,
  input  logic                     cfgInTiled,
  input  logic                     cfgOutTiled,
  input  logic [DIM_W-1:0]         outW,
  input  logic [DIM_W-1:0]         curX,
  input  logic [DIM_W-1:0]         curY,
  input  logic [LANES_N*PIX_W-1:0] rdData,
  input  logic                     wrReady,
  output logic [ADDR_W-1:0]        rdAddr,
  output logic                     wrValid,
  output logic [ADDR_W-1:0]        wrAddr,
  output logic [PIX_W-1:0]         wrData,
  output logic                     outFree,
  output logic                     wrIdle
);
  localparam int SUM_W = CHAN_W + 2;

  logic [ADDR_W-1:0] srcBase, dstBase;
  logic [DIM_W-1:0]  inW;
  logic [1:0]        scaleR;
  logic              inTiledR, outTiledR;

  function automatic logic [ADDR_W-1:0] tiledOff(input logic [DIM_W-1:0] x,
                                                 input logic [DIM_W-1:0] y,
                                                 input logic [DIM_W-1:0] w);
    logic [5:0]        idx;
    logic [ADDR_W-1:0] pix;
    idx = {y[2], x[2], y[1], x[1], y[0], x[0]};
    pix = ADDR_W'(idx) + (ADDR_W'(x >> 3) << 6) + ((ADDR_W'(y >> 3) * ADDR_W'(w)) << 3);
    return pix * ADDR_W'(BYTES_PP);
  endfunction

  function automatic logic [ADDR_W-1:0] linearOff(input logic [DIM_W-1:0] x,
                                                  input logic [DIM_W-1:0] y,
                                                  input logic [DIM_W-1:0] w);
    return (ADDR_W'(x) + ADDR_W'(y) * ADDR_W'(w)) * ADDR_W'(BYTES_PP);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcBase   <= '0;
      dstBase   <= '0;
      inW       <= '0;
      scaleR    <= SCL_NONE;
      inTiledR  <= 1'b0;
      outTiledR <= 1'b0;
    end else if (strobe.loadCfg) begin
      srcBase   <= cfgSrcBase;
      dstBase   <= cfgDstBase;
      inW       <= cfgWidth;
      scaleR    <= cfgScale;
      inTiledR  <= cfgInTiled;
      outTiledR <= cfgOutTiled;
    end
  end

  logic [DIM_W-1:0]  inX, inY;
  logic [ADDR_W-1:0] dstNext;

  always_comb begin
    inX     = (scaleR != SCL_NONE) ? (curX << 1) : curX;
    inY     = (scaleR == SCL_XY) ? (curY << 1) : curY;
    rdAddr  = srcBase + (inTiledR ? tiledOff(inX, inY, inW) : linearOff(inX, inY, inW));
    dstNext = dstBase + (outTiledR ? tiledOff(curX, curY, outW) : linearOff(curX, curY, outW));
  end

  logic [PIX_W-1:0] avgPix;

  for (genvar c = 0; c < CHAN_N; c++) begin : g_chan
    logic [SUM_W-1:0] pairSum, quadSum;
    assign pairSum = SUM_W'(rdData[0*PIX_W + c*CHAN_W +: CHAN_W])
                   + SUM_W'(rdData[1*PIX_W + c*CHAN_W +: CHAN_W]);
    assign quadSum = pairSum
                   + SUM_W'(rdData[2*PIX_W + c*CHAN_W +: CHAN_W])
                   + SUM_W'(rdData[3*PIX_W + c*CHAN_W +: CHAN_W]);
    assign avgPix[c*CHAN_W +: CHAN_W] =
        (scaleR == SCL_X)  ? pairSum[CHAN_W:1] :
        (scaleR == SCL_XY) ? quadSum[CHAN_W+1:2] :
                             rdData[c*CHAN_W +: CHAN_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrValid <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
    end else if (strobe.rdFire) begin
      wrValid <= 1'b1;
      wrAddr  <= dstNext;
      wrData  <= avgPix;
    end else if (wrReady) begin
      wrValid <= 1'b0;
    end
  end

  assign outFree = !wrValid || wrReady;
  assign wrIdle  = !wrValid;

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrAddr) && $stable(wrData))); // R8
  AST_READ_FEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdFire |=> wrValid); // R3
endmodule

// File: rtl/dtx_engine.sv
module dtx_engine
  import dtx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [ADDR_W-1:0]        cfgSrcBase,
  input  logic [ADDR_W-1:0]        cfgDstBase,
  input  logic [DIM_W-1:0]         cfgWidth,
  input  logic [DIM_W-1:0]         cfgHeight,
  input  logic [1:0]               cfgScale,
  input  logic                     cfgInTiled,
  input  logic                     cfgOutTiled,
  output logic                     busy,
  output logic                     done,
  output logic                     errFlag,
  output logic                     rdValid,
  input  logic                     rdReady,
  output logic [ADDR_W-1:0]        rdAddr,
  input  logic [LANES_N*PIX_W-1:0] rdData,
  output logic                     wrValid,
  input  logic                     wrReady,
  output logic [ADDR_W-1:0]        wrAddr,
  output logic [PIX_W-1:0]         wrData
);
  ctrl_strobe_t     strobe;
  logic             outFree, wrIdle;
  logic [DIM_W-1:0] outW, outH, curX, curY;

  dtx_ctrl #(.DIM_W(DIM_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .cfgWidth(cfgWidth), .cfgHeight(cfgHeight), .cfgScale(cfgScale), .cfgInTiled(cfgInTiled),
    .outFree(outFree), .wrIdle(wrIdle), .rdReady(rdReady), .rdValid(rdValid),
    .busy(busy), .done(done), .errFlag(errFlag), .strobe(strobe),
    .outW(outW), .outH(outH), .curX(curX), .curY(curY)
  );

  dtx_datapath #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgSrcBase(cfgSrcBase), .cfgDstBase(cfgDstBase), .cfgWidth(cfgWidth),
    .cfgScale(cfgScale), .cfgInTiled(cfgInTiled), .cfgOutTiled(cfgOutTiled),
    .outW(outW), .curX(curX), .curY(curY), .rdData(rdData), .wrReady(wrReady),
    .rdAddr(rdAddr), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .outFree(outFree), .wrIdle(wrIdle)
  );
endmodule

// File: tb/sim_dtx_engine.sv
module sim_dtx_engine;
  localparam int AW = 32;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] cfgSrcBase = 32'h0010_0000;
  logic [AW-1:0] cfgDstBase = 32'h0080_0000;
  logic [DW-1:0] cfgWidth = 8'd16;
  logic [DW-1:0] cfgHeight = 8'd16;
  logic [1:0]    cfgScale = 2'd0;
  logic          cfgInTiled = 1'b0;
  logic          cfgOutTiled = 1'b0;
  logic          busy, done, errFlag, rdValid, wrValid;
  logic          rdReady = 1'b1;
  logic          wrReady = 1'b1;
  logic [AW-1:0] rdAddr, wrAddr;
  logic [127:0]  rdData;
  logic [31:0]   wrData;

  int nCmp = 0, nBad = 0, rdCnt = 0, wrCnt = 0, cyc = 0;
  bit stall = 1'b0;
  int expW = 0, expOutW = 0, expOutH = 0, expSc = 0;
  bit expInT = 1'b0, expOutT = 1'b0;
  logic [31:0] expSrc = '0, expDst = '0;

  always #10 clk = ~clk;

  dtx_engine #(.ADDR_W(AW), .DIM_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .cfgSrcBase(cfgSrcBase), .cfgDstBase(cfgDstBase),
    .cfgWidth(cfgWidth), .cfgHeight(cfgHeight), .cfgScale(cfgScale), .cfgInTiled(cfgInTiled),
    .cfgOutTiled(cfgOutTiled), .busy(busy), .done(done), .errFlag(errFlag),
    .rdValid(rdValid), .rdReady(rdReady), .rdAddr(rdAddr), .rdData(rdData),
    .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ {a[15:0], a[31:16]};
  endfunction

  function automatic int mortonIdx(input int x, input int y);
    int m = 0;
    for (int b = 0; b < 3; b++) begin
      m += ((x >> b) & 1) << (2 * b);
      m += ((y >> b) & 1) << (2 * b + 1);
    end
    return m;
  endfunction

  function automatic int byteOff(input bit tiled, input int x, input int y, input int w);
    if (tiled) return (mortonIdx(x, y) + (x / 8) * 64 + (y / 8) * 8 * w) * 4;
    return (x + y * w) * 4;
  endfunction

  always_comb begin
    for (int k = 0; k < 4; k++) rdData[k*32 +: 32] = memWord(rdAddr + 32'(4 * k));
  end

  task automatic chk(input bit ok, input string msg);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic checkPixel();
    int ox, oy, ix, iy, n, sum;
    logic [31:0] ea, ed, so, wv;
    if (expOutW == 0) begin
      chk(1'b0, $sformatf("R3 write with no pixels due: actual addr %h expected none", wrAddr));
      return;
    end
    ox = wrCnt % expOutW;
    oy = wrCnt / expOutW;
    ix = (expSc != 0) ? 2 * ox : ox;
    iy = (expSc == 2) ? 2 * oy : oy;
    n  = (expSc == 0) ? 1 : (expSc == 1) ? 2 : 4;
    so = expSrc + 32'(byteOff(expInT, ix, iy, expW));
    ea = expDst + 32'(byteOff(expOutT, ox, oy, expOutW));
    for (int c = 0; c < 4; c++) begin
      sum = 0;
      for (int k = 0; k < n; k++) begin
        wv = memWord(so + 32'(4 * k));
        sum += int'(wv[c*8 +: 8]);
      end
      ed[c*8 +: 8] = 8'(sum / n);
    end
    chk(wrAddr == ea && wrData == ed,
        $sformatf("R4 R5 R6 mode %0d pixel (%0d,%0d): actual %h/%h expected %h/%h",
                  expSc, ox, oy, wrAddr, wrData, ea, ed));
  endtask

  initial forever begin
    @(negedge clk);
    cyc++;
    rdReady = stall ? (cyc % 3 != 0) : 1'b1;
    wrReady = stall ? (cyc % 5 != 1) : 1'b1;
    #2;
    if (rdValid && rdReady) rdCnt++;
    if (wrValid && wrReady) begin
      checkPixel();
      wrCnt++;
    end
  end

  task automatic runXfer(input int w, input int h, input int sc, input bit inT, input bit outT,
                         input bit stl, input bit poke);
    int t = 0;
    expW = w; expSc = sc; expInT = inT; expOutT = outT;
    expOutW = (sc != 0) ? w / 2 : w;
    expOutH = (sc == 2) ? h / 2 : h;
    expSrc = cfgSrcBase; expDst = cfgDstBase;
    cfgWidth = 8'(w); cfgHeight = 8'(h); cfgScale = 2'(sc);
    cfgInTiled = inT; cfgOutTiled = outT; stall = stl;
    @(negedge clk);
    rdCnt = 0; wrCnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, $sformatf("R7 busy after start: actual %0b expected 1", busy));
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
      if (poke && t == 3) begin
        start = 1'b1; cfgScale = 2'd3; cfgWidth = 8'd4;
      end else if (poke && t == 4) begin
        start = 1'b0;
      end
    end
    chk(done == 1'b1, $sformatf("R7 done seen: actual %0b expected 1", done));
    chk(busy == 1'b0, $sformatf("R7 busy with done: actual %0b expected 0", busy));
    chk(wrCnt == expOutW * expOutH,
        $sformatf("R3 write count %0dx%0d mode %0d: actual %0d expected %0d",
                  w, h, sc, wrCnt, expOutW * expOutH));
    chk(rdCnt == expOutW * expOutH,
        $sformatf("R3 read count: actual %0d expected %0d", rdCnt, expOutW * expOutH));
    chk(errFlag == 1'b0, $sformatf("R9 R10 errFlag after run: actual %0b expected 0", errFlag));
    @(negedge clk);
    chk(done == 1'b0, $sformatf("R7 done width: actual %0b expected 0", done));
  endtask

  task automatic refuse(input int sc, input bit inT, input string tag);
    expOutW = 0; expOutH = 0;
    cfgWidth = 8'd16; cfgHeight = 8'd16; cfgScale = 2'(sc); cfgInTiled = inT; cfgOutTiled = 1'b0;
    @(negedge clk);
    rdCnt = 0; wrCnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk(errFlag == 1'b1, $sformatf("%s errFlag: actual %0b expected 1", tag, errFlag));
    chk(busy == 1'b0, $sformatf("%s busy: actual %0b expected 0", tag, busy));
    chk(rdCnt == 0 && wrCnt == 0,
        $sformatf("%s traffic: actual %0d/%0d expected 0/0", tag, rdCnt, wrCnt));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !errFlag && !rdValid && !wrValid,
        $sformatf("R9 reset state: actual %0b%0b%0b%0b%0b expected 00000",
                  busy, done, errFlag, rdValid, wrValid));
    rstN = 1'b1;
    @(negedge clk);
    runXfer(16, 16, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    runXfer(16,  8, 0, 1'b0, 1'b1, 1'b1, 1'b0);
    runXfer(24, 16, 0, 1'b1, 1'b0, 1'b0, 1'b0);
    runXfer(16, 16, 0, 1'b1, 1'b1, 1'b1, 1'b0);
    runXfer(32,  8, 1, 1'b1, 1'b0, 1'b0, 1'b0);
    runXfer(16, 16, 1, 1'b1, 1'b1, 1'b1, 1'b0);
    runXfer(16, 16, 2, 1'b1, 1'b0, 1'b0, 1'b0);
    runXfer(32, 16, 2, 1'b1, 1'b1, 1'b1, 1'b0);
    runXfer( 8,  8, 2, 1'b1, 1'b1, 1'b0, 1'b0);
    runXfer( 1,  4, 1, 1'b1, 1'b0, 1'b0, 1'b0);
    refuse(3, 1'b1, "R1 mode 3");
    runXfer(16,  8, 0, 1'b1, 1'b1, 1'b0, 1'b0);
    refuse(1, 1'b0, "R2 linear halve-x");
    refuse(2, 1'b0, "R2 linear halve-xy");
    runXfer(16, 16, 2, 1'b1, 1'b0, 1'b1, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    nBad++;
    $display("FAIL watchdog expired: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule